// File: doc/BRIEF.md
# Low-Order Path V5 Overhead Generator

This block forms the V5 overhead byte of one transmit VC-12 tributary, once per 500 us multiframe. A one-cycle boundary strobe marks the start of each multiframe. On that cycle the block samples three sets of inputs. The first is the remote defect status that the receive side of the same tributary reports. The second is the configuration bits: automatic enable and force for each of the two remote indications, the remote failure value, and the 3-bit signal label. The third is the global selection between the two unequipped modes. From these it builds the new V5 byte and holds it in a register until the next boundary. A single V5 byte therefore never mixes old and new settings.

The block also watches the transmitted VC-12 byte stream, V5 included. It keeps a running 2-bit interleaved even parity of that stream and places the parity of the previous multiframe in the first two bits of the next V5. A signal label of zero puts the tributary into the unequipped state. Two outputs then tell the framing logic which bytes to clear: the payload and N2 in both unequipped modes, and J2 as well in plain unequipped mode only.

Top module: `v5_oh_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first boundary strobe, `v5_byte` equals 8'h04, and `zero_payload` and `zero_j2` are 0. In that byte the label field carries 010, the asynchronous mapping code.
- R2: `v5_byte` takes a new value only on the clock cycle after a cycle with `mf_tick` high. Changes on any other input between strobes leave it unchanged.
- R3: `v5_byte[7]` is the even parity of bits 7, 5, 3 and 1 over all bytes accepted with `vc_vld` since the previous strobe. `v5_byte[6]` is the even parity of bits 6, 4, 2 and 0 over the same bytes. A byte accepted in the strobe cycle itself counts toward the following multiframe.
- R4: The remote defect indication `v5_byte[0]` is `cfg_rdi_frc OR (cfg_rdi_en AND any bit of rem_defect)`. The bits of `rem_defect` are: bit 0 TU-AIS, bit 1 TU-LOP, bit 2 J2 trace mismatch, bit 3 unequipped.
- R5: The remote error indication `v5_byte[5]` is `cfg_rei_frc OR (cfg_rei_en AND rem_err)`.
- R6: For a nonzero `cfg_label`, `v5_byte[4]` equals `cfg_rfi`, `v5_byte[3:1]` equals `cfg_label`, and both zeroing outputs are 0. `cfg_uneq_sup` has no effect.
- R7: For `cfg_label` = 000 with `cfg_uneq_sup` = 0, `v5_byte[5:0]` is all zero whatever the alarm, force and RFI inputs. `zero_payload` and `zero_j2` are both 1.
- R8: For `cfg_label` = 000 with `cfg_uneq_sup` = 1, REI and RDI follow R5 and R4, RFI and the label field are 0, `zero_payload` is 1 and `zero_j2` is 0.
- R9: `zero_payload` and `zero_j2` change only on the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mf_tick | input | 1 | One-cycle multiframe boundary strobe |
| vc_vld | input | 1 | A transmitted VC-12 byte is present on `vc_byte` |
| vc_byte | input | 8 | Transmitted VC-12 byte, V5 included |
| rem_defect | input | 4 | Receive-side defects: 0 AIS, 1 LOP, 2 trace mismatch, 3 unequipped |
| rem_err | input | 1 | Receive side requests a remote error indication |
| cfg_rdi_en | input | 1 | Automatic RDI enable |
| cfg_rdi_frc | input | 1 | Force RDI to 1 |
| cfg_rei_en | input | 1 | Automatic REI enable |
| cfg_rei_frc | input | 1 | Force REI to 1 |
| cfg_rfi | input | 1 | Processor-set remote failure bit |
| cfg_label | input | 3 | Signal label; 000 selects unequipped |
| cfg_uneq_sup | input | 1 | 1 selects supervisory unequipped |
| v5_byte | output | 8 | V5 byte of the current multiframe |
| zero_payload | output | 1 | Clear payload and N2 (unequipped) |
| zero_j2 | output | 1 | Clear J2 as well (plain unequipped) |

## Verification
Every result is due exactly one clock after the strobe cycle. The V5 byte and both zeroing flags are loaded by the same edge that samples `mf_tick`. The bench drives inputs on the falling edge and reads outputs on the falling edge that follows the strobe. It then changes every configuration and defect input while feeding bytes for several cycles, and it expects no output to move before the next strobe. The parity it expects comes from its own byte-wise fold of the stream it sent, and the byte given in the strobe cycle is credited to the following multiframe.

// File: rtl/v5_oh_pkg.sv
package v5_oh_pkg;
   localparam int unsigned V5_BYTE_W   = 8;
   localparam int unsigned V5_BIP_W    = 2;
   localparam int unsigned V5_LBL_W    = 3;
   localparam int unsigned V5_N_DEF    = 4;
   localparam logic [V5_LBL_W-1:0] V5_LBL_ASYNC = 3'b010;
   localparam logic [V5_LBL_W-1:0] V5_LBL_UNEQ  = 3'b000;
   // remote defect flag positions
   localparam int unsigned DEF_AIS  = 0;
   localparam int unsigned DEF_LOP  = 1;
   localparam int unsigned DEF_TIM  = 2;
   localparam int unsigned DEF_UNEQ = 3;
endpackage

// File: rtl/v5_oh_bip.sv
module v5_oh_bip #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_d,
   output logic [LANES-1:0]  bip
);
   logic [DATA_W-1:0] acc_q;

   // running XOR of every byte; the boundary byte opens the new frame
   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else if (boundary)
         acc_q <= byte_vld ? byte_d : '0;
      else if (byte_vld)
         acc_q <= acc_q ^ byte_d;
   end

   // lane l covers the bits whose MSB-first position index mod LANES is l
   generate
      for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
         logic par;
         always_comb begin
            par = 1'b0;
            for (int i = 0; i < int'(DATA_W); i++) begin
               if (((int'(DATA_W) - 1 - i) % int'(LANES)) == l)
                  par = par ^ acc_q[i];
            end
         end
         assign bip[int'(LANES) - 1 - l] = par;
      end
   endgenerate
endmodule

// File: rtl/v5_oh_alarm.sv
module v5_oh_alarm #(
   parameter int unsigned N_IN = 1
) (
   input  logic            en,
   input  logic            frc,
   input  logic [N_IN-1:0] flags,
   output logic            ind
);
   assign ind = frc | (en & (|flags));
endmodule

// File: rtl/v5_oh_gen.sv
module v5_oh_gen #(
   parameter int unsigned BYTE_W = v5_oh_pkg::V5_BYTE_W,
   parameter int unsigned BIP_W  = v5_oh_pkg::V5_BIP_W,
   parameter int unsigned LBL_W  = v5_oh_pkg::V5_LBL_W,
   parameter int unsigned N_DEF  = v5_oh_pkg::V5_N_DEF,
   parameter logic [LBL_W-1:0] LBL_RST = v5_oh_pkg::V5_LBL_ASYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mf_tick,
   input  logic              vc_vld,
   input  logic [BYTE_W-1:0] vc_byte,
   input  logic [N_DEF-1:0]  rem_defect,
   input  logic              rem_err,
   input  logic              cfg_rdi_en,
   input  logic              cfg_rdi_frc,
   input  logic              cfg_rei_en,
   input  logic              cfg_rei_frc,
   input  logic              cfg_rfi,
   input  logic [LBL_W-1:0]  cfg_label,
   input  logic              cfg_uneq_sup,
   output logic [BYTE_W-1:0] v5_byte,
   output logic              zero_payload,
   output logic              zero_j2
);
   localparam int unsigned POS_RDI    = 0;
   localparam int unsigned POS_LBL_LO = 1;
   localparam int unsigned POS_RFI    = LBL_W + 1;
   localparam int unsigned POS_REI    = LBL_W + 2;
   localparam int unsigned FIELD_W    = BIP_W + LBL_W + 3;
   localparam logic [BYTE_W-1:0] V5_RST =
      {{(BYTE_W-LBL_W-1){1'b0}}, LBL_RST, 1'b0};

   generate
      if (FIELD_W != BYTE_W) begin : g_bad_layout
         $error("V5 fields do not fill the byte");
      end
      if ((BYTE_W % BIP_W) != 0) begin : g_bad_bip
         $error("parity lanes must divide the byte width");
      end
      if (N_DEF == 0) begin : g_bad_def
         $error("at least one remote defect flag is needed");
      end
   endgenerate

   logic [BIP_W-1:0]  bip_w;
   logic              rdi_w;
   logic              rei_w;
   logic              uneq_w;
   logic [BYTE_W-1:0] v5_next;
   logic [BYTE_W-1:0] v5_q;
   logic              zp_q;
   logic              zj_q;

   v5_oh_bip #(.DATA_W(BYTE_W), .LANES(BIP_W)) u_bip (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (mf_tick),
      .byte_vld (vc_vld),
      .byte_d   (vc_byte),
      .bip      (bip_w)
   );

   v5_oh_alarm #(.N_IN(N_DEF)) u_rdi (
      .en    (cfg_rdi_en),
      .frc   (cfg_rdi_frc),
      .flags (rem_defect),
      .ind   (rdi_w)
   );

   v5_oh_alarm #(.N_IN(1)) u_rei (
      .en    (cfg_rei_en),
      .frc   (cfg_rei_frc),
      .flags (rem_err),
      .ind   (rei_w)
   );

   assign uneq_w = (cfg_label == v5_oh_pkg::V5_LBL_UNEQ);

   always_comb begin
      v5_next = '0;
      v5_next[BYTE_W-1 -: BIP_W] = bip_w;
      if (!uneq_w || cfg_uneq_sup) begin
         v5_next[POS_REI] = rei_w;
         v5_next[POS_RDI] = rdi_w;
      end
      if (!uneq_w) begin
         v5_next[POS_RFI] = cfg_rfi;
         v5_next[POS_LBL_LO +: LBL_W] = cfg_label;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v5_q <= V5_RST;
         zp_q <= 1'b0;
         zj_q <= 1'b0;
      end else if (mf_tick) begin
         v5_q <= v5_next;
         zp_q <= uneq_w;
         zj_q <= uneq_w & ~cfg_uneq_sup;
      end
   end

   assign v5_byte      = v5_q;
   assign zero_payload = zp_q;
   assign zero_j2      = zj_q;
endmodule

// File: rtl/v5_oh_gen_chk.sv
module v5_oh_gen_chk #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LBL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mf_tick,
   input logic              cfg_rdi_frc,
   input logic              cfg_rei_frc,
   input logic [LBL_W-1:0]  cfg_label,
   input logic              cfg_uneq_sup,
   input logic [BYTE_W-1:0] v5_byte,
   input logic              zero_payload,
   input logic              zero_j2
);
   // R2
   v5_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_tick |=> $stable(v5_byte));

   // R9
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_tick |=> ($stable(zero_payload) && $stable(zero_j2)));

   // R4
   rdi_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_tick && cfg_rdi_frc && (cfg_label != '0 || cfg_uneq_sup)) |=> v5_byte[0]);

   // R5
   rei_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_tick && cfg_rei_frc && (cfg_label != '0 || cfg_uneq_sup)) |=> v5_byte[LBL_W+2]);

   // R6
   label_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_tick && cfg_label != '0) |=>
         (v5_byte[LBL_W:1] == $past(cfg_label) && !zero_payload && !zero_j2));

   // R7
   uneq_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_tick && cfg_label == '0 && !cfg_uneq_sup) |=>
         (v5_byte[LBL_W+2:0] == '0 && zero_payload && zero_j2));

   // R8
   uneq_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_tick && cfg_label == '0 && cfg_uneq_sup) |=>
         (v5_byte[LBL_W+1:1] == '0 && zero_payload && !zero_j2));
endmodule

bind v5_oh_gen v5_oh_gen_chk #(.BYTE_W(BYTE_W), .LBL_W(LBL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mf_tick      (mf_tick),
   .cfg_rdi_frc  (cfg_rdi_frc),
   .cfg_rei_frc  (cfg_rei_frc),
   .cfg_label    (cfg_label),
   .cfg_uneq_sup (cfg_uneq_sup),
   .v5_byte      (v5_byte),
   .zero_payload (zero_payload),
   .zero_j2      (zero_j2)
);

// File: tb/v5_oh_gen_test.sv
module v5_oh_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mf_tick = 1'b0;
   logic       vc_vld = 1'b0;
   logic [7:0] vc_byte = '0;
   logic [3:0] rem_defect = '0;
   logic       rem_err = 1'b0;
   logic       cfg_rdi_en = 1'b1;
   logic       cfg_rdi_frc = 1'b0;
   logic       cfg_rei_en = 1'b1;
   logic       cfg_rei_frc = 1'b0;
   logic       cfg_rfi = 1'b0;
   logic [2:0] cfg_label = 3'b010;
   logic       cfg_uneq_sup = 1'b0;
   logic [7:0] v5_byte;
   logic       zero_payload;
   logic       zero_j2;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic [7:0] bacc = '0;

   always #4 clk = ~clk;

   v5_oh_gen uut (
      .clk(clk), .rst_n(rst_n), .mf_tick(mf_tick), .vc_vld(vc_vld),
      .vc_byte(vc_byte), .rem_defect(rem_defect), .rem_err(rem_err),
      .cfg_rdi_en(cfg_rdi_en), .cfg_rdi_frc(cfg_rdi_frc),
      .cfg_rei_en(cfg_rei_en), .cfg_rei_frc(cfg_rei_frc),
      .cfg_rfi(cfg_rfi), .cfg_label(cfg_label), .cfg_uneq_sup(cfg_uneq_sup),
      .v5_byte(v5_byte), .zero_payload(zero_payload), .zero_j2(zero_j2)
   );

   // {label[21:19], sup[18], rdi_en[17], rdi_frc[16], rei_en[15], rei_frc[14],
   //  rfi[13], defects[12:9], err[8], expected v5[5:0] at [7:2], zp[1], zj[0]}
   localparam logic [21:0] VEC [12] = '{
      {3'b010, 1'b0, 4'b1010, 1'b0, 4'b0000, 1'b0, 6'b000100, 2'b00},
      {3'b010, 1'b0, 4'b1010, 1'b0, 4'b0001, 1'b1, 6'b100101, 2'b00},
      {3'b001, 1'b0, 4'b0000, 1'b1, 4'b1111, 1'b1, 6'b010010, 2'b00},
      {3'b101, 1'b0, 4'b0101, 1'b0, 4'b0000, 1'b0, 6'b101011, 2'b00},
      {3'b010, 1'b0, 4'b1000, 1'b0, 4'b0100, 1'b1, 6'b000101, 2'b00},
      {3'b011, 1'b0, 4'b0010, 1'b1, 4'b1000, 1'b1, 6'b110110, 2'b00},
      {3'b000, 1'b0, 4'b1111, 1'b1, 4'b1111, 1'b1, 6'b000000, 2'b11},
      {3'b000, 1'b1, 4'b1010, 1'b1, 4'b0010, 1'b1, 6'b100001, 2'b10},
      {3'b000, 1'b1, 4'b0000, 1'b0, 4'b1111, 1'b1, 6'b000000, 2'b10},
      {3'b111, 1'b1, 4'b0100, 1'b0, 4'b0000, 1'b1, 6'b001111, 2'b00},
      {3'b000, 1'b1, 4'b0101, 1'b1, 4'b0000, 1'b0, 6'b100001, 2'b10},
      {3'b110, 1'b0, 4'b1010, 1'b0, 4'b1000, 1'b0, 6'b001101, 2'b00}
   };

   function automatic logic [1:0] bip_of(input logic [7:0] a);
      return {^(a & 8'hAA), ^(a & 8'h55)};
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply_cfg(input logic [21:0] v);
      cfg_label    = v[21:19];
      cfg_uneq_sup = v[18];
      cfg_rdi_en   = v[17];
      cfg_rdi_frc  = v[16];
      cfg_rei_en   = v[15];
      cfg_rei_frc  = v[14];
      cfg_rfi      = v[13];
      rem_defect   = v[12:9];
      rem_err      = v[8];
   endtask

   // strobe with row v; optional byte in the strobe cycle; check one cycle later
   task automatic tick(input logic [21:0] v, input bit tb_vld,
                       input logic [7:0] tb_byte, input string tag);
      logic [7:0] exp_v5;
      @(negedge clk);
      apply_cfg(v);
      mf_tick = 1'b1;
      vc_vld  = tb_vld;
      vc_byte = tb_byte;
      exp_v5  = {bip_of(bacc), v[7:2]};
      bacc    = tb_vld ? tb_byte : 8'h00;
      @(negedge clk);
      mf_tick = 1'b0;
      vc_vld  = 1'b0;
      check(v5_byte == exp_v5, {tag, " v5"}, 32'(v5_byte), 32'(exp_v5));
      check({zero_payload, zero_j2} == v[1:0], {tag, " zero flags R7 R8 R9"},
            32'({zero_payload, zero_j2}), 32'(v[1:0]));
   endtask

   // feed bytes with scrambled settings; outputs must hold (R2, R9)
   task automatic disturb(input int seed);
      logic [7:0] held_v5;
      logic [1:0] held_z;
      held_v5 = v5_byte;
      held_z  = {zero_payload, zero_j2};
      for (int k = 0; k < 6; k++) begin
         cfg_label    = ~cfg_label;
         cfg_uneq_sup = ~cfg_uneq_sup;
         cfg_rdi_en   = ~cfg_rdi_en;
         cfg_rdi_frc  = ~cfg_rdi_frc;
         cfg_rei_en   = ~cfg_rei_en;
         cfg_rei_frc  = ~cfg_rei_frc;
         cfg_rfi      = ~cfg_rfi;
         rem_defect   = ~rem_defect;
         rem_err      = ~rem_err;
         vc_vld  = 1'b1;
         vc_byte = (k == 0) ? v5_byte : 8'((seed * 37) + (k * 73) + 29);
         bacc    = bacc ^ vc_byte;
         @(negedge clk);
      end
      vc_vld = 1'b0;
      check(v5_byte == held_v5, "R2 hold between strobes",
            32'(v5_byte), 32'(held_v5));
      check({zero_payload, zero_j2} == held_z, "R9 flags hold between strobes",
            32'({zero_payload, zero_j2}), 32'(held_z));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(v5_byte == 8'h04, "R1 v5 during reset", 32'(v5_byte), 32'h04);
      check({zero_payload, zero_j2} == 2'b00, "R1 flags during reset",
            32'({zero_payload, zero_j2}), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(v5_byte == 8'h04, "R1 v5 after reset release", 32'(v5_byte), 32'h04);

      for (int i = 0; i < 12; i++) begin
         tick(VEC[i], 1'b0, 8'h00, "R3 R4 R5 R6 table row");
         disturb(i);
      end

      // R3: byte in the strobe cycle belongs to the next multiframe
      @(negedge clk);
      vc_vld = 1'b1; vc_byte = 8'h01; bacc = bacc ^ 8'h01;
      @(negedge clk);
      vc_vld = 1'b0;
      tick(VEC[0], 1'b1, 8'h80, "R3 boundary byte excluded");
      tick(VEC[0], 1'b0, 8'h00, "R3 boundary byte counted");
      check(v5_byte[7:6] == 2'b10, "R3 bip of single 80h", 32'(v5_byte[7:6]), 32'h2);
      tick(VEC[0], 1'b0, 8'h00, "R3 empty multiframe");
      check(v5_byte[7:6] == 2'b00, "R3 empty bip", 32'(v5_byte[7:6]), 32'h0);

      // R7 then R8 on back-to-back strobes, force bits set
      tick(VEC[6], 1'b0, 8'h00, "R7 plain unequipped");
      tick(VEC[10], 1'b0, 8'h00, "R8 supervisory unequipped");

      // R1: reset in mid-run restores the default byte
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(v5_byte == 8'h04, "R1 v5 after mid-run reset", 32'(v5_byte), 32'h04);
      check({zero_payload, zero_j2} == 2'b00, "R1 flags after mid-run reset",
            32'({zero_payload, zero_j2}), 32'h0);
      rst_n = 1'b1;
      bacc = 8'h00;
      tick(VEC[1], 1'b0, 8'h00, "R4 R5 after reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule